// File: doc/BRIEF.md
# Latching Interrupt Controller with Selectable Acknowledge Polarity

The block collects 32 interrupt request lines next to a processor core. Each line has one bit in a status register that records a pending request and one bit in a mask register that decides whether that pending request reaches the core. While any bit is both pending and enabled, a single registered request line to the core is held high. Bit i of each register always belongs to input i, with bit 0 for input 0, so software can walk the status word from the low end to find its sources.

Software reaches the two registers through a small special-register port. There is a write strobe, one select for the mask, one select for the status, a write word and a read word. Unmasking and masking are done by read-modify-write of the mask. A build parameter picks how a pending bit is acknowledged. In the standard convention, a written 1 clears the bit. In the inverted convention, a written 0 clears the bit, so software writes back the status it read with only the target bit cleared. A second parameter marks which inputs are level type. In the standard convention, a level input's status bit simply tracks the input. In the inverted convention, a level input is latched like an edge input and stays set until software clears it.

Top module: `irq_latch_ctrl`

## Requirements
- R1: While reset is asserted, and at the first read after reset, the mask, the status and the core request are all zero.
- R2: For an edge-type input, a low-to-high change between two clock edges sets its status bit at the second edge, whatever the mask bit is. An input that is simply held high does not set the bit again once it has been cleared.
- R3: In the standard convention (ACK_MODE = ACK_WRITE_ONE), a status write clears every latched bit where the write word has a 1. Bits where the word has a 0 are left unchanged.
- R4: In the inverted convention (ACK_MODE = ACK_WRITE_ZERO), a status write clears every latched bit where the write word has a 0. Bits where the word has a 1 are left unchanged.
- R5: In the standard convention, the status bit of a level-type input (LEVEL_MAP bit = 1) equals the input as sampled at the previous clock edge, and status writes have no effect on it.
- R6: In the inverted convention, the status bit of a level-type input is set at any edge where the input is high. It stays set after the input falls, until a status write clears it.
- R7: A mask write loads the full 32-bit word at the clock edge, and an all-zero mask can be held. A mask bit of 1 lets the matching status bit drive the core request; a mask bit of 0 blocks it.
- R8: The core request equals the OR of (status AND mask) as it stood one clock edge earlier.
- R9: If a new request and a status-clearing write hit the same bit at the same edge, the bit is set after that edge.
- R10: The read word is combinational. It shows the mask when the mask select is high, otherwise the status when the status select is high, and otherwise zero. Bit i corresponds to input i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 32 | Interrupt request inputs, bit i is source i |
| spr_we | input | 1 | Register write strobe |
| spr_sel_mask | input | 1 | Selects the mask register |
| spr_sel_stat | input | 1 | Selects the status register |
| spr_wdata | input | 32 | Register write word |
| spr_rdata | output | 32 | Register read word |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
Two functions can meet at one edge: latching a new request and a software acknowledge aimed at the same status bit. The bench provokes this by raising an edge input that was already latched and dropped, in the same cycle as a clearing status write in each convention. It judges the result by reading the status word afterwards, where the bit must still be set. A behavioural model also runs for both conventions and is compared with the read word and the core request on every clock.

// File: rtl/irq_latch_pkg.sv
// Package: shared types for the latching interrupt controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package irq_latch_pkg;

    // Acknowledge polarity of the status register.
    typedef enum logic {
        ACK_WRITE_ONE  = 1'b0,   // a written 1 clears the bit
        ACK_WRITE_ZERO = 1'b1    // a written 0 clears the bit
    } ack_mode_e;

endpackage

// File: rtl/irq_edge_detect.sv
// Module: irq_edge_detect
// Registers each request input and flags a low-to-high change.
// Assumes the inputs are already synchronous to clk.
module irq_edge_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    // Hold the previous-cycle value of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req_i;
    end

    assign rise_o = req_i & ~prev_q;

endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Software-loaded enable word, one bit per source, cleared by reset.
// Assumes the write enable is already qualified by the select.
module irq_mask_reg #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_o
);

    // Load the whole word on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_o <= '0;
        else if (wr_en) mask_o <= wdata;
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module: irq_status_bank
// Pending-request register. Per bit, the build parameters pick one of:
// tracking a level input, latching a level input, or latching a rising edge.
// A set and a clear on the same bit at the same edge leave the bit set.
// Assumes clr_i is already decoded into a per-bit clear request.
module irq_status_bank
    import irq_latch_pkg::*;
#(
    parameter int        N         = 32,
    parameter logic [N-1:0] LEVEL_MAP = '0,
    parameter ack_mode_e ACK_MODE  = ACK_WRITE_ONE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o
);

    localparam logic [N-1:0] FOLLOW_MAP = (ACK_MODE == ACK_WRITE_ONE) ? LEVEL_MAP : '0;

    logic [N-1:0] stat_nxt;

    // Next-state selection for every status bit.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (FOLLOW_MAP[i])      stat_nxt[i] = req_i[i];
            else if (LEVEL_MAP[i])  stat_nxt[i] = req_i[i]  | (stat_o[i] & ~clr_i[i]);
            else                    stat_nxt[i] = rise_i[i] | (stat_o[i] & ~clr_i[i]);
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= stat_nxt;
    end

endmodule

// File: rtl/irq_latch_ctrl.sv
// Module: irq_latch_ctrl (top)
// Interrupt controller with a mask and a latched status word, a register port
// and one registered request to the core. ACK_MODE picks the acknowledge
// polarity; LEVEL_MAP marks level-type sources.
// Assumes register-port accesses are single-cycle and synchronous to clk.
module irq_latch_ctrl
    import irq_latch_pkg::*;
#(
    parameter int        N         = 32,
    parameter logic [N-1:0] LEVEL_MAP = '0,
    parameter ack_mode_e ACK_MODE  = ACK_WRITE_ONE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_src,
    input  logic         spr_we,
    input  logic         spr_sel_mask,
    input  logic         spr_sel_stat,
    input  logic [N-1:0] spr_wdata,
    output logic [N-1:0] spr_rdata,
    output logic         cpu_irq
);

    logic [N-1:0] rise_vec;
    logic [N-1:0] mask_q;
    logic [N-1:0] stat_q;
    logic [N-1:0] clr_vec;
    logic         stat_wr;

    irq_edge_detect #(.N(N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_src),
        .rise_o (rise_vec)
    );

    irq_mask_reg #(.N(N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (spr_we & spr_sel_mask),
        .wdata  (spr_wdata),
        .mask_o (mask_q)
    );

    assign stat_wr = spr_we & spr_sel_stat;

    // Translate the write word into per-bit clears for the chosen polarity.
    generate
        if (ACK_MODE == ACK_WRITE_ZERO) begin : g_ack_zero
            assign clr_vec = stat_wr ? ~spr_wdata : '0;
        end else begin : g_ack_one
            assign clr_vec = stat_wr ? spr_wdata : '0;
        end
    endgenerate

    irq_status_bank #(.N(N), .LEVEL_MAP(LEVEL_MAP), .ACK_MODE(ACK_MODE)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_src),
        .rise_i (rise_vec),
        .clr_i  (clr_vec),
        .stat_o (stat_q)
    );

    // Read multiplexer; the mask select has priority.
    always_comb begin
        if (spr_sel_mask)      spr_rdata = mask_q;
        else if (spr_sel_stat) spr_rdata = stat_q;
        else                   spr_rdata = '0;
    end

    // Registered request to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= |(stat_q & mask_q);
    end

endmodule

// File: rtl/irq_latch_chk.sv
// Module: irq_latch_chk
// Property checker bound into irq_latch_ctrl.
// Assumes the same parameters as the instance it is bound to.
module irq_latch_chk
    import irq_latch_pkg::*;
#(
    parameter int        N         = 32,
    parameter logic [N-1:0] LEVEL_MAP = '0,
    parameter ack_mode_e ACK_MODE  = ACK_WRITE_ONE
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] irq_src,
    input logic         spr_we,
    input logic         spr_sel_mask,
    input logic         spr_sel_stat,
    input logic [N-1:0] spr_wdata,
    input logic [N-1:0] mask_q,
    input logic [N-1:0] stat_q,
    input logic [N-1:0] rise_vec,
    input logic         cpu_irq
);

    localparam logic [N-1:0] EDGE_BITS = ~LEVEL_MAP;

    logic [N-1:0] ack_bits;
    assign ack_bits = (ACK_MODE == ACK_WRITE_ZERO) ? ~spr_wdata : spr_wdata;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && stat_q == '0 && cpu_irq == 1'b0));

    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cpu_irq == |($past(stat_q & mask_q))));

    // R2 and R9
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise_vec & EDGE_BITS)) |=>
        ((stat_q & $past(rise_vec & EDGE_BITS)) == $past(rise_vec & EDGE_BITS)));

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && spr_sel_mask) |=> (mask_q == $past(spr_wdata)));

    // R3 and R4
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && spr_sel_stat) |=>
        ((stat_q & $past(ack_bits & ~rise_vec & EDGE_BITS)) == '0));

    generate
        if (ACK_MODE == ACK_WRITE_ONE) begin : g_std
            // R5
            level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ((stat_q & LEVEL_MAP) == ($past(irq_src) & LEVEL_MAP)));
        end else begin : g_alt
            // R6
            level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|(irq_src & LEVEL_MAP)) |=>
                ((stat_q & $past(irq_src & LEVEL_MAP)) == $past(irq_src & LEVEL_MAP)));
        end
    endgenerate

endmodule

bind irq_latch_ctrl irq_latch_chk #(
    .N(N), .LEVEL_MAP(LEVEL_MAP), .ACK_MODE(ACK_MODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_src      (irq_src),
    .spr_we       (spr_we),
    .spr_sel_mask (spr_sel_mask),
    .spr_sel_stat (spr_sel_stat),
    .spr_wdata    (spr_wdata),
    .mask_q       (mask_q),
    .stat_q       (stat_q),
    .rise_vec     (rise_vec),
    .cpu_irq      (cpu_irq)
);

// File: tb/irq_latch_ctrl_test.sv
`timescale 1ns/1ps
// Bench: drives a standard-convention instance (uut) and an inverted one
// (uut_z) from the same stimulus, checks both against a behavioural model
// on every clock, and runs directed scenarios with hand-computed values.
module irq_latch_ctrl_test;
    import irq_latch_pkg::*;

    localparam logic [31:0] LVL = 32'hFF00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        we = 1'b0, sel_m = 1'b0, sel_s = 1'b0;
    logic [31:0] ws = '0, wz = '0;
    logic [31:0] rd_s, rd_z;
    logic        irq_s, irq_z;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_latch_ctrl #(.N(32), .LEVEL_MAP(LVL), .ACK_MODE(ACK_WRITE_ONE)) uut (
        .clk(clk), .rst_n(rst_n), .irq_src(src), .spr_we(we),
        .spr_sel_mask(sel_m), .spr_sel_stat(sel_s), .spr_wdata(ws),
        .spr_rdata(rd_s), .cpu_irq(irq_s));

    irq_latch_ctrl #(.N(32), .LEVEL_MAP(LVL), .ACK_MODE(ACK_WRITE_ZERO)) uut_z (
        .clk(clk), .rst_n(rst_n), .irq_src(src), .spr_we(we),
        .spr_sel_mask(sel_m), .spr_sel_stat(sel_s), .spr_wdata(wz),
        .spr_rdata(rd_z), .cpu_irq(irq_z));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model for both conventions.
    logic [31:0] m_mask_s = '0, m_mask_z = '0, m_st_s = '0, m_st_z = '0, m_prev = '0;
    logic        m_irq_s = 1'b0, m_irq_z = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask_s = '0; m_mask_z = '0; m_st_s = '0; m_st_z = '0;
            m_prev = '0; m_irq_s = 1'b0; m_irq_z = 1'b0;
        end else begin
            m_irq_s = |(m_st_s & m_mask_s);
            m_irq_z = |(m_st_z & m_mask_z);
            for (int i = 0; i < 32; i++) begin
                bit rise, cs, cz;
                rise = src[i] && !m_prev[i];
                cs = we && sel_s && ws[i];
                cz = we && sel_s && !wz[i];
                if (LVL[i]) begin
                    m_st_s[i] = src[i];
                    m_st_z[i] = src[i] || (m_st_z[i] && !cz);
                end else begin
                    m_st_s[i] = rise || (m_st_s[i] && !cs);
                    m_st_z[i] = rise || (m_st_z[i] && !cz);
                end
            end
            if (we && sel_m) begin
                m_mask_s = ws;
                m_mask_z = wz;
            end
            m_prev = src;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 core request std", {31'd0, irq_s}, {31'd0, m_irq_s});
            chk("R8 core request inv", {31'd0, irq_z}, {31'd0, m_irq_z});
            chk("R10 read word std", rd_s, sel_m ? m_mask_s : (sel_s ? m_st_s : 32'd0));
            chk("R10 read word inv", rd_z, sel_m ? m_mask_z : (sel_s ? m_st_z : 32'd0));
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input bit m, input logic [31:0] s, input logic [31:0] z);
        we = 1'b1; sel_m = m; sel_s = !m; ws = s; wz = z;
        @(posedge clk); #1;
        we = 1'b0; sel_m = 1'b0; sel_s = 1'b0;
    endtask

    task automatic rd(input bit m, output logic [31:0] s, output logic [31:0] z);
        sel_m = m; sel_s = !m;
        @(negedge clk);
        s = rd_s; z = rd_z;
        @(posedge clk); #1;
        sel_m = 1'b0; sel_s = 1'b0;
    endtask

    logic [31:0] a, b;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset std", {31'd0, irq_s}, 32'd0);
        chk("R1 irq in reset inv", {31'd0, irq_z}, 32'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        rd(1, a, b); chk("R1 mask std", a, 0); chk("R1 mask inv", b, 0);
        rd(0, a, b); chk("R1 stat std", a, 0); chk("R1 stat inv", b, 0);

        // Edge latch while masked.
        src[3] = 1'b1; step(1); src[3] = 1'b0;
        rd(0, a, b); chk("R2 edge latch std", a, 32'h8); chk("R2 edge latch inv", b, 32'h8);
        @(negedge clk); chk("R7 masked no irq", {31'd0, irq_s}, 0);
        @(posedge clk); #1;

        // Unmask, request appears.
        wr(1, 32'h8, 32'h8); step(1);
        @(negedge clk);
        chk("R8 irq after unmask std", {31'd0, irq_s}, 1);
        chk("R8 irq after unmask inv", {31'd0, irq_z}, 1);
        @(posedge clk); #1;

        // Non-clearing writes, then clearing writes.
        wr(0, 32'h0, 32'hFFFF_FFFF);
        rd(0, a, b); chk("R3 zero keeps", a, 32'h8); chk("R4 one keeps", b, 32'h8);
        wr(0, 32'h8, ~32'h8);
        rd(0, a, b); chk("R3 one clears", a, 0); chk("R4 zero clears", b, 0);
        @(negedge clk);
        chk("R8 irq drops std", {31'd0, irq_s}, 0);
        chk("R8 irq drops inv", {31'd0, irq_z}, 0);
        @(posedge clk); #1;

        // Held-high edge input does not re-latch.
        src[5] = 1'b1; step(1);
        rd(0, a, b); chk("R2 held set std", a, 32'h20); chk("R2 held set inv", b, 32'h20);
        wr(0, 32'h20, ~32'h20);
        rd(0, a, b); chk("R2 held no relatch std", a, 0); chk("R2 held no relatch inv", b, 0);
        src[5] = 1'b0;

        // Level input on bit 24.
        src[24] = 1'b1; step(1);
        wr(0, 32'h0100_0000, ~32'h0100_0000);
        rd(0, a, b); chk("R5 level write ignored", a, 32'h0100_0000);
        chk("R6 level held while high", b, 32'h0100_0000);
        src[24] = 1'b0; step(1);
        rd(0, a, b); chk("R5 level follows low", a, 0); chk("R6 level stays latched", b, 32'h0100_0000);
        wr(0, 32'h0, ~32'h0100_0000);
        rd(0, a, b); chk("R6 level cleared", b, 0);

        // Same-edge set and clear on bit 7.
        src[7] = 1'b1; step(1); src[7] = 1'b0; step(1);
        src[7] = 1'b1;
        wr(0, 32'h80, ~32'h80);
        rd(0, a, b); chk("R9 set wins std", a, 32'h80); chk("R9 set wins inv", b, 32'h80);
        src[7] = 1'b0;
        wr(0, 32'h80, ~32'h80);
        rd(0, a, b); chk("R9 later clear std", a, 0); chk("R9 later clear inv", b, 0);

        // Full-word mask load and read-back, no-select read.
        wr(1, 32'hA5A5_5A5A, 32'h5A5A_A5A5);
        rd(1, a, b); chk("R7 mask readback std", a, 32'hA5A5_5A5A); chk("R7 mask readback inv", b, 32'h5A5A_A5A5);
        @(negedge clk); chk("R10 no select", rd_s, 0);
        @(posedge clk); #1;
        wr(1, 32'h0, 32'h0);
        rd(1, a, b); chk("R7 all-zero mask", a | b, 0);

        step(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R1 act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule